// File: doc/BRIEF.md
# SPI Command Slave for an H-Bridge Channel

This block is the byte-wide serial slave that sits in front of one motor bridge channel. A host lowers the chip select, clocks eight bits in on SI and reads eight bits out on SO, then raises the chip select. The top three bits of each received byte pick an operation. Two write operations load a five-bit control word. The others read the diagnosis byte, the control word or a fixed revision byte, or clear the diagnosis. The answer to a byte always travels in the next frame.

Between the start of a frame and the first serial clock, SO carries an error flag instead of data. The flag is the bridge shutdown indication ORed with the SI pin, so several channels can pass one combined flag along a chain. All serial pins are brought into a faster system clock through two-flop synchronisers, and every action is taken on the synchronised edges. A separate input lets the bridge logic drop the register-control mode bit whenever its direct control pins move.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset the control word is 0, SO is not driven, and the first reply is the revision byte {4'b0010, REV}.
- R2: SI is sampled on SCK falling edges, most significant bit first. SO presents the reply most significant bit first, and each bit appears on an SCK rising edge.
- R3: The reply shifted out in a frame answers the command of the most recent complete frame before it.
- R4: Operation codes in bits 7:5: 000 selects diagnosis, 001 selects revision, and 011 selects control. Code 111 writes bits 4:0 to the control word and selects control. Code 110 writes bits 4:0 and selects diagnosis. The control reply is {operation code that selected it, control word}.
- R5: Code 100 raises diag_clr for exactly one system clock at the end of the frame and selects diagnosis.
- R6: Codes 010 and 101 select diagnosis and change nothing else.
- R7: A frame with fewer than 8 SCK falling edges writes nothing, pulses nothing and leaves the reply selection as it was.
- R8: A frame with more than 8 SCK falling edges is decoded from the last 8 bits received.
- R9: While CSN is low and before the first SCK rising edge, SO equals fault_off OR si.
- R10: SO is not driven (so_en low) while CSN is high.
- R11: ctrl_clr clears control bit 3 (register-control mode) and prevents a write from setting it while high. The other bits are not affected.
- R12: ctrl_out changes only at the end of a valid write frame or through ctrl_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (valid while so_en is high) |
| so_en | output | 1 | Drive enable for SO; low means high impedance |
| fault_off | input | 1 | Bridge outputs are shut down by a fault or disabled |
| diag_in | input | 8 | Current diagnosis byte |
| ctrl_clr | input | 1 | Clear request for the register-control mode bit |
| ctrl_out | output | 5 | Control word |
| diag_clr | output | 1 | One-cycle diagnosis clear pulse |

## Verification
The main decode is driven with every defined operation code, both undefined codes, and a write whose data bits would be visible if ignored. The expected reply lags one frame behind, which separates a correct pipeline from one that answers the current byte. Frames of 4, 8 and 12 clocks show whether a short frame is discarded and whether a long frame keeps the last eight bits rather than the first. The error-flag window is probed with fault and SI in each combination, and the mode-bit clear is tried both as a pulse and held across a write.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    SEL_DIAG = 2'd0,
    SEL_REV  = 2'd1,
    SEL_CTRL = 2'd2
  } resp_sel_t;

  localparam logic [2:0] OP_RD_DIAG  = 3'b000;
  localparam logic [2:0] OP_RD_REV   = 3'b001;
  localparam logic [2:0] OP_RD_CTRL  = 3'b011;
  localparam logic [2:0] OP_CLR_DIAG = 3'b100;
  localparam logic [2:0] OP_WR_DIAG  = 3'b110;
  localparam logic [2:0] OP_WR_CTRL  = 3'b111;

  typedef struct packed {
    resp_sel_t sel;
    logic      wr;
    logic      clr;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [2:0] op);
    op_dec_t d;
    d.sel = SEL_DIAG;
    d.wr  = 1'b0;
    d.clr = 1'b0;
    case (op)
      OP_RD_REV:   d.sel = SEL_REV;
      OP_RD_CTRL:  d.sel = SEL_CTRL;
      OP_WR_CTRL:  begin d.sel = SEL_CTRL; d.wr = 1'b1; end
      OP_WR_DIAG:  d.wr = 1'b1;
      OP_CLR_DIAG: d.clr = 1'b1;
      default:     d.sel = SEL_DIAG;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] rev_word(input logic [3:0] rev);
    return {4'b0010, rev};
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] chain [W];

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {STAGES{RST_VAL[g]}};
      else        chain[g] <= {chain[g][STAGES-2:0], d[g]};
    end
    assign q[g] = chain[g][STAGES-1];
  end
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         frame_start,
  input  logic         frame_end,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         si_bit,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] rx_word,
  output logic         rx_full,
  output logic         started,
  output logic         tx_msb
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx_word <= '0;
      tx_q    <= '0;
      started <= 1'b0;
    end else if (frame_start) begin
      cnt     <= '0;
      tx_q    <= load_word;
      started <= 1'b0;
    end else if (frame_end) begin
      started <= 1'b0;
    end else if (active) begin
      if (sck_fall) begin
        rx_word <= {rx_word[W-2:0], si_bit};
        if (cnt != CNT_W'(W)) cnt <= cnt + 1'b1;
      end
      if (sck_rise) begin
        if (started) tx_q <= {tx_q[W-2:0], 1'b0};
        started <= 1'b1;
      end
    end
  end

  assign rx_full = (cnt == CNT_W'(W));
  assign tx_msb  = tx_q[W-1];
endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg #(
  parameter int W = 5,
  parameter int MODE_BIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         mode_clr,
  output logic [W-1:0] ctrl
);
  logic [W-1:0] next_w;

  always_comb begin
    next_w = wr_data;
    if (mode_clr) next_w[MODE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl <= '0;
    else if (wr_en)    ctrl <= next_w;
    else if (mode_clr) ctrl[MODE_BIT] <= 1'b0;
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W = 3,
  parameter int MODE_BIT = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] REV = 4'h5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csn,
  input  logic                   sck,
  input  logic                   si,
  output logic                   so,
  output logic                   so_en,
  input  logic                   fault_off,
  input  logic [DATA_W-1:0]      diag_in,
  input  logic                   ctrl_clr,
  output logic [DATA_W-OP_W-1:0] ctrl_out,
  output logic                   diag_clr
);
  localparam int CTRL_W = DATA_W - OP_W;

  logic csn_s, sck_s, si_s;
  logic csn_q, sck_q;
  logic frame_start, frame_end, sck_rise, sck_fall;
  logic [DATA_W-1:0] rx_word, load_word;
  logic rx_full, started, tx_msb;
  resp_sel_t resp_sel;
  logic [OP_W-1:0] resp_op;
  op_dec_t dec;
  logic cmd_valid, wr_en;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({csn, sck, si}),
    .q({csn_s, sck_s, si_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign frame_start = csn_q & ~csn_s;
  assign frame_end   = ~csn_q & csn_s;
  assign sck_rise    = ~sck_q & sck_s & ~csn_s;
  assign sck_fall    = sck_q & ~sck_s & ~csn_s;

  always_comb begin
    case (resp_sel)
      SEL_REV:  load_word = DATA_W'(rev_word(REV));
      SEL_CTRL: load_word = {resp_op, ctrl_out};
      default:  load_word = diag_in;
    endcase
  end

  spi_frame_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .active(~csn_s),
    .frame_start(frame_start), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_s), .load_word(load_word),
    .rx_word(rx_word), .rx_full(rx_full),
    .started(started), .tx_msb(tx_msb)
  );

  assign dec       = decode_op(rx_word[DATA_W-1 -: OP_W]);
  assign cmd_valid = frame_end & rx_full;
  assign wr_en     = cmd_valid & dec.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_sel <= SEL_REV;
      resp_op  <= '0;
      diag_clr <= 1'b0;
    end else begin
      diag_clr <= cmd_valid & dec.clr;
      if (cmd_valid) begin
        resp_sel <= dec.sel;
        resp_op  <= rx_word[DATA_W-1 -: OP_W];
      end
    end
  end

  spi_ctrl_reg #(.W(CTRL_W), .MODE_BIT(MODE_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(rx_word[CTRL_W-1:0]),
    .mode_clr(ctrl_clr), .ctrl(ctrl_out)
  );

  assign so_en = ~csn_s;
  assign so    = started ? tx_msb : (fault_off | si);
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int CTRL_W = 5,
  parameter int MODE_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              sck_rise,
  input logic              started,
  input logic              so,
  input logic              diag_clr,
  input logic              ctrl_clr,
  input logic [CTRL_W-1:0] ctrl_out
);
  // R5: clear pulse lasts a single cycle
  a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |=> !diag_clr);

  // R5: clear pulse only follows a frame end
  a_r5_clr_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |-> $past(frame_end));

  // R12: control word only moves at a frame end or through the clear input
  a_r12_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !ctrl_clr) |=> $stable(ctrl_out));

  // R11: clear leaves the mode bit low
  a_r11_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> !ctrl_out[MODE_BIT]);

  // R2: once shifting, SO moves only on an SCK rising edge
  a_r2_so_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !sck_rise && !frame_end) |=> $stable(so));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.CTRL_W(DATA_W - OP_W), .MODE_BIT(MODE_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .sck_rise(sck_rise),
  .started(started), .so(so), .diag_clr(diag_clr), .ctrl_clr(ctrl_clr),
  .ctrl_out(ctrl_out)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, si = 1'b0;
  logic fault_off = 1'b0, ctrl_clr = 1'b0;
  logic [7:0] diag_in = 8'h9B;
  logic so, so_en, diag_clr;
  logic [4:0] ctrl_out;

  int errors = 0;
  int checks = 0;
  int clr_cnt = 0;
  localparam logic [7:0] REV_B = 8'h25;
  localparam logic [7:0] DIAG = 8'h9B;

  always #2.5 clk = ~clk;

  spi_cmd_slave #(.REV(4'h5)) dut_i (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .si(si),
    .so(so), .so_en(so_en), .fault_off(fault_off), .diag_in(diag_in),
    .ctrl_clr(ctrl_clr), .ctrl_out(ctrl_out), .diag_clr(diag_clr)
  );

  always @(posedge clk) if (diag_clr) clr_cnt <= clr_cnt + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] word, input int nbits, output logic [7:0] reply);
    reply = '0;
    @(negedge clk);
    csn = 1'b0; si = 1'b0;
    wait_n(10);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = word[i];
      wait_n(2);
      sck = 1'b1;
      wait_n(10);
      if (nbits - 1 - i < 8) reply[7 - (nbits - 1 - i)] = so;
      sck = 1'b0;
      wait_n(10);
    end
    csn = 1'b1;
    wait_n(10);
  endtask

  task automatic t_reset;
    chk("R1 ctrl after reset", {3'b0, ctrl_out}, 8'h00);
    chk("R1 so_en idle", {7'b0, so_en}, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] r;
    xfer(16'h00, 8, r); chk("R1 first reply revision", r, REV_B);
    xfer(16'h60, 8, r); chk("R3 lag diag reply", r, DIAG);
    xfer(16'hF5, 8, r); chk("R4 ctrl readback 011", r, 8'h60);
    chk("R4 write 111", {3'b0, ctrl_out}, 8'h15);
    xfer(16'hCA, 8, r); chk("R4 ctrl readback 111", r, 8'hF5);
    chk("R4 write 110", {3'b0, ctrl_out}, 8'h0A);
    xfer(16'h40, 8, r); chk("R4 110 returns diag", r, DIAG);
    xfer(16'hBF, 8, r); chk("R6 code 010 diag", r, DIAG);
    chk("R12 ctrl untouched by 101", {3'b0, ctrl_out}, 8'h0A);
    xfer(16'h20, 8, r); chk("R6 code 101 diag", r, DIAG);
    xfer(16'h00, 8, r); chk("R4 revision read", r, REV_B);
  endtask

  task automatic t_clear;
    logic [7:0] r;
    int c0;
    c0 = clr_cnt;
    xfer(16'h80, 8, r); chk("R4 000 diag reply", r, DIAG);
    chk("R5 one clear pulse", 8'(clr_cnt - c0), 8'd1);
    xfer(16'h60, 8, r); chk("R5 clear returns diag", r, DIAG);
    chk("R5 no extra pulse", 8'(clr_cnt - c0), 8'd1);
  endtask

  task automatic t_short_long;
    logic [7:0] r;
    int c0;
    c0 = clr_cnt;
    xfer(16'h000F, 4, r);
    chk("R7 short frame no write", {3'b0, ctrl_out}, 8'h0A);
    chk("R7 short frame no pulse", 8'(clr_cnt - c0), 8'd0);
    xfer(16'h00, 8, r); chk("R7 selection kept", r, 8'h6A);
    xfer(16'h0FE3, 12, r); chk("R8 long frame reply", r, DIAG);
    chk("R8 last 8 bits written", {3'b0, ctrl_out}, 8'h03);
    xfer(16'h00, 8, r); chk("R8 readback", r, 8'hE3);
  endtask

  task automatic flag_case(input logic f, input logic s, input logic exp);
    @(negedge clk);
    fault_off = f; si = s; csn = 1'b0;
    wait_n(10);
    chk("R9 flag so_en", {7'b0, so_en}, 8'h01);
    chk("R9 flag value", {7'b0, so}, {7'b0, exp});
    csn = 1'b1; si = 1'b0; fault_off = 1'b0;
    wait_n(10);
  endtask

  task automatic t_flag;
    chk("R10 idle not driven", {7'b0, so_en}, 8'h00);
    flag_case(1'b1, 1'b0, 1'b1);
    flag_case(1'b0, 1'b0, 1'b0);
    flag_case(1'b0, 1'b1, 1'b1);
    chk("R7 zero-clock frame no write", {3'b0, ctrl_out}, 8'h03);
  endtask

  task automatic t_mode_clr;
    logic [7:0] r;
    xfer(16'hEC, 8, r);
    chk("R11 mode bit set", {3'b0, ctrl_out}, 8'h0C);
    @(negedge clk); ctrl_clr = 1'b1;
    @(negedge clk); ctrl_clr = 1'b0;
    wait_n(2);
    chk("R11 clear pulse drops mode", {3'b0, ctrl_out}, 8'h04);
    ctrl_clr = 1'b1;
    xfer(16'hEE, 8, r);
    chk("R11 held clear blocks mode", {3'b0, ctrl_out}, 8'h06);
    ctrl_clr = 1'b0;
    wait_n(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_decode();
    t_clear();
    t_short_long();
    t_flag();
    t_mode_clr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule